// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns a comparator's "supply is above its threshold" signal into a clean system reset. While the supply is low, or before it has first come up, the reset pin is driven to its asserted level and the memory write-inhibit output is raised. Once the supply recovers, reset is held for a fixed number of clock cycles and then the pin is released.

The pin is modelled as open drain. The block either drives the asserted level or lets go. With the default active-low polarity the pin is also read back, so a push button that pulls it low acts as a manual reset. A debounced press starts a reset that lasts as long as the button is held. After the button is released, the same full timeout follows. During the whole manual phase the block does not drive the pin itself, and it ignores what it reads back while it is driving, so it cannot latch itself in reset.

The interfaces are plain level signals, so there is no valid/ready stream and no back-pressure.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While the logic reset `rst_n` is low, and afterwards until the supply has been seen high, `rst_active_o`, `pad_oe_o` and `wr_inhibit_o` are all 1.
- R2: From any state, a low on `supply_ok_i` makes `rst_active_o` and `pad_oe_o` equal to 1 within two clock edges.
- R3: After `supply_ok_i` rises and stays high, `rst_active_o` is still 1 after 2+TIMEOUT_CYCLES edges and becomes 0 after 3+TIMEOUT_CYCLES edges.
- R4: A supply dip that occurs during the timeout restarts the full timeout, measured from the new rise.
- R5: `pad_oe_o` is 1 only while `rst_active_o` is 1. `pad_o` is 0 when ACTIVE_LOW=1 and 1 when ACTIVE_LOW=0.
- R6: `wr_inhibit_o` equals the inverse of `supply_ok_i` delayed by two clock edges, and is 1 out of logic reset.
- R7: With ACTIVE_LOW=1, holding `pad_i` at 0 from outside drives `rst_active_o` to 1 within 3+DEBOUNCE_CYCLES edges. While the pin stays held, `rst_active_o` stays 1 and `pad_oe_o` stays 0.
- R8: An external pull that lasts fewer than DEBOUNCE_CYCLES synchronized cycles leaves `rst_active_o` at 0.
- R9: After a manual press is released, `pad_oe_o` and `rst_active_o` are 1 after 3+DEBOUNCE_CYCLES edges. `rst_active_o` falls exactly TIMEOUT_CYCLES edges later.
- R10: The block's own drive of the pin, and the pin level it reads back for SYNC_STAGES+1 cycles after the drive stops, never starts a manual reset. After a timed release, reset stays released.
- R11: With ACTIVE_LOW=0, the level on `pad_i` has no effect on `rst_active_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| supply_ok_i | input | 1 | Asynchronous comparator output, 1 when the supply is above threshold |
| pad_i | input | 1 | Level read back from the reset pin |
| pad_oe_o | output | 1 | Open-drain enable: 1 drives `pad_o` onto the pin |
| pad_o | output | 1 | Asserted level of the pin (polarity set by ACTIVE_LOW) |
| rst_active_o | output | 1 | 1 while system reset is asserted for any reason |
| wr_inhibit_o | output | 1 | 1 while the synchronized supply is below threshold |

## Verification
The hardest case to reach is the moment the block stops driving the pin. The pin's previous asserted level is then still moving through the sense synchronizer, and a missing blanking window would let that stale level start a reset by itself. The bench drives the sequence press, hold, release, timed hold and release through a pin model that combines the block's drive with a button. It then watches for a further 20 cycles to confirm that reset stays released. Short presses below the debounce length, and a supply dip in the middle of the timeout, are stepped through the same vector table.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_LOW    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_RUN    = 2'd2,
    ST_MANUAL = 2'd3
  } supv_state_e;
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int DEBOUNCE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_i,
  input  logic blank_i,
  output logic level_o
);
  localparam int CNT_W = $clog2(DEBOUNCE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (blank_i) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (sense_i != level_q) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        level_q <= sense_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/supv_timeout.sv
module supv_timeout #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl
  import supv_pkg::*;
#(
  parameter int TIMEOUT_CYCLES  = 10_000_000,
  parameter int DEBOUNCE_CYCLES = 1_000_000,
  parameter int SYNC_STAGES     = 2,
  parameter bit ACTIVE_LOW      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic pad_i,
  output logic pad_oe_o,
  output logic pad_o,
  output logic rst_active_o,
  output logic wr_inhibit_o
);
  localparam logic ASSERT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;
  localparam int   BLANK_LEN  = SYNC_STAGES + 1;

  supv_state_e state_q, state_d;
  logic supply_s;
  logic hold_done;
  logic man_level;
  logic drive;

  supv_sync #(.STAGES(SYNC_STAGES)) u_supply_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (supply_ok_i),
    .q_o  (supply_s)
  );

  supv_timeout #(.CYCLES(TIMEOUT_CYCLES)) u_timeout (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q == ST_HOLD),
    .done_o(hold_done)
  );

  generate
    if (ACTIVE_LOW) begin : g_manual
      logic sense_s;
      logic blank;
      logic [BLANK_LEN-1:0] drive_hist_q;

      supv_sync #(.STAGES(SYNC_STAGES)) u_pad_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pad_i == ASSERT_LVL),
        .q_o  (sense_s)
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drive_hist_q <= '1;
        else        drive_hist_q <= {drive_hist_q[BLANK_LEN-2:0], drive};
      end

      assign blank = drive || (|drive_hist_q);

      supv_debounce #(.DEBOUNCE(DEBOUNCE_CYCLES)) u_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .sense_i(sense_s),
        .blank_i(blank),
        .level_o(man_level)
      );
    end else begin : g_no_manual
      logic unused_pad;
      assign unused_pad = pad_i;
      assign man_level  = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    if (!supply_s) begin
      state_d = ST_LOW;
    end else begin
      case (state_q)
        ST_LOW:    state_d = ST_HOLD;
        ST_HOLD:   if (hold_done) state_d = ST_RUN;
        ST_RUN:    if (man_level) state_d = ST_MANUAL;
        ST_MANUAL: if (!man_level) state_d = ST_HOLD;
        default:   state_d = ST_LOW;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOW;
    else        state_q <= state_d;
  end

  assign drive        = !supply_s || (state_q == ST_LOW) || (state_q == ST_HOLD);
  assign pad_oe_o     = drive;
  assign pad_o        = ASSERT_LVL;
  assign rst_active_o = drive || (state_q == ST_MANUAL);
  assign wr_inhibit_o = !supply_s;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_i,
  input logic pad_oe_o,
  input logic rst_active_o,
  input logic wr_inhibit_o
);
  AST_DRIVE_MEANS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe_o |-> rst_active_o); // R5

  AST_LOW_SUPPLY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit_o |-> (pad_oe_o && rst_active_o)); // R2

  AST_INHIBIT_FOLLOWS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_inhibit_o |-> $past(supply_ok_i, 2)); // R6

  AST_RELEASE_WITH_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active_o) |-> !wr_inhibit_o); // R3

  AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active_o) |-> $past(pad_oe_o)); // R9
endmodule

bind supv_reset_ctrl supv_reset_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok_i (supply_ok_i),
  .pad_oe_o    (pad_oe_o),
  .rst_active_o(rst_active_o),
  .wr_inhibit_o(wr_inhibit_o)
);

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;
  localparam int T = 20;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply = 1'b0;
  logic btn = 1'b0;
  logic hi_force = 1'b0;

  logic oe_lo, po_lo, act_lo, inh_lo, pad_lo;
  logic oe_hi, po_hi, act_hi, inh_hi, pad_hi;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign pad_lo = oe_lo ? po_lo : (btn ? 1'b0 : 1'b1);
  assign pad_hi = oe_hi ? po_hi : hi_force;

  supv_reset_ctrl #(.TIMEOUT_CYCLES(T), .DEBOUNCE_CYCLES(D), .SYNC_STAGES(2), .ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply), .pad_i(pad_lo),
    .pad_oe_o(oe_lo), .pad_o(po_lo), .rst_active_o(act_lo), .wr_inhibit_o(inh_lo)
  );

  supv_reset_ctrl #(.TIMEOUT_CYCLES(T), .DEBOUNCE_CYCLES(D), .SYNC_STAGES(2), .ACTIVE_LOW(1'b0)) u_dut_hi (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply), .pad_i(pad_hi),
    .pad_oe_o(oe_hi), .pad_o(po_hi), .rst_active_o(act_hi), .wr_inhibit_o(inh_hi)
  );

  // {supply, button, wait[7:0], exp_active, exp_oe, exp_inhibit, req[4:0]}
  localparam int NV = 16;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd2,     1'b1, 1'b1, 1'b0, 5'd6},  // R6 inhibit drops, still held
    {1'b1, 1'b0, 8'(T),    1'b1, 1'b1, 1'b0, 5'd3},  // R3 2+T edges: held
    {1'b1, 1'b0, 8'd1,     1'b0, 1'b0, 1'b0, 5'd3},  // R3 3+T edges: released
    {1'b1, 1'b1, 8'd2,     1'b0, 1'b0, 1'b0, 5'd8},  // R8 short press begins
    {1'b1, 1'b0, 8'd10,    1'b0, 1'b0, 1'b0, 5'd8},  // R8 short press ignored
    {1'b1, 1'b1, 8'(D+3),  1'b1, 1'b0, 1'b0, 5'd7},  // R7 manual detected
    {1'b1, 1'b1, 8'd20,    1'b1, 1'b0, 1'b0, 5'd7},  // R7 held while pressed
    {1'b1, 1'b0, 8'(D+3),  1'b1, 1'b1, 1'b0, 5'd9},  // R9 timed hold begins
    {1'b1, 1'b0, 8'(T-1),  1'b1, 1'b1, 1'b0, 5'd9},  // R9 still held
    {1'b1, 1'b0, 8'd1,     1'b0, 1'b0, 1'b0, 5'd9},  // R9 released
    {1'b1, 1'b0, 8'd20,    1'b0, 1'b0, 1'b0, 5'd10}, // R10 no self-latch
    {1'b0, 1'b0, 8'd2,     1'b1, 1'b1, 1'b1, 5'd2},  // R2 supply loss
    {1'b1, 1'b0, 8'd12,    1'b1, 1'b1, 1'b0, 5'd4},  // R4 mid timeout
    {1'b0, 1'b0, 8'd2,     1'b1, 1'b1, 1'b1, 5'd4},  // R4 dip
    {1'b1, 1'b0, 8'(T+2),  1'b1, 1'b1, 1'b0, 5'd4},  // R4 full restart
    {1'b1, 1'b0, 8'd1,     1'b0, 1'b0, 1'b0, 5'd4}   // R4 released
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #5;
    check("R1", "active in reset", act_lo, 1'b1);
    check("R1", "oe in reset", oe_lo, 1'b1);
    check("R1", "inhibit in reset", inh_lo, 1'b1);
    check("R5", "pad level active-low", po_lo, 1'b0);
    check("R5", "pad level active-high", po_hi, 1'b1);
    check("R5", "pin driven low", pad_lo, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #5;
    check("R1", "active before supply", act_lo, 1'b1);
    check("R1", "inhibit before supply", inh_lo, 1'b1);
    check("R1", "oe before supply", oe_lo, 1'b1);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      supply = VEC[i][17];
      btn    = VEC[i][16];
      repeat (int'(VEC[i][15:8])) @(posedge clk);
      #5;
      check($sformatf("R%0d", VEC[i][4:0]), $sformatf("vec %0d active", i), act_lo, VEC[i][7]);
      check($sformatf("R%0d", VEC[i][4:0]), $sformatf("vec %0d oe", i), oe_lo, VEC[i][6]);
      check($sformatf("R%0d", VEC[i][4:0]), $sformatf("vec %0d inhibit", i), inh_lo, VEC[i][5]);
      check("R5", $sformatf("vec %0d oe implies active", i), (!oe_lo) || act_lo, 1'b1);
    end

    // R11: active-high variant ignores an external pull on its pin
    check("R11", "hi variant released", act_hi, 1'b0);
    @(negedge clk);
    hi_force = 1'b1;
    repeat (30) @(posedge clk);
    #5;
    check("R11", "hi variant ignores pin", act_hi, 1'b0);
    check("R11", "hi variant not driving", oe_hi, 1'b0);
    @(negedge clk);
    hi_force = 1'b0;

    // R2 and R5 on the active-high variant: supply loss drives the pin high
    supply = 1'b0;
    repeat (2) @(posedge clk);
    #5;
    check("R2", "hi variant active on loss", act_hi, 1'b1);
    check("R5", "hi variant pin driven high", pad_hi, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule